// File: doc/BRIEF.md
# Cache-Line Next-Fetch Branch Predictor

This block holds one prediction record for every line of a 1024-line instruction cache. The fetch logic presents a line index on the lookup port. One cycle later the block answers with three values for that line. The first is the offset of the final byte expected to execute inside the 16-byte fetch block. The second is a one-bit taken/not-taken guess. The third is the line index that fetch should visit next: the stored branch-target line when the line predicts taken, otherwise the following line.

Three update sources act on the records. When prefetch installs a line, a fill request resets that line to a not-taken default. A resolve request, issued after a misprediction, replaces the record with the outcome actually observed, but only when the branch came from cacheable memory. A flush wipes all predictions in a single cycle. Each record carries its own valid flag, which is cleared on flush, so no sweep through the array is needed.

The scheme is single-bit. The stored bit is whatever the last resolve wrote, and a resolve simply overwrites the whole record.

Top module: `cbp_line_predictor`

## Requirements
- R1: `lk_vld_o` is high in exactly the cycle after a cycle in which `lk_req` was high, and low otherwise; the other lookup outputs belong to the index presented in that earlier cycle.
- R2: After reset, every line reads as not-taken, with `lk_last_o` = 15 and `lk_next_o` = index + 1.
- R3: A resolve with `fix_cacheable` = 1 and `fix_taken` = 1 stores the outcome, last-byte offset and successor index. Later lookups of that line return `lk_taken_o` = 1, the stored `lk_last_o`, and `lk_next_o` equal to the stored successor.
- R4: A cacheable resolve with `fix_taken` = 0 makes the line read not-taken, with the supplied `lk_last_o` and `lk_next_o` = index + 1.
- R5: A resolve with `fix_cacheable` = 0 leaves the stored prediction of its line unchanged.
- R6: A fill makes its line read not-taken, with `lk_last_o` = 15 and `lk_next_o` = index + 1, even if the line previously predicted taken.
- R7: A cycle with `flush` high clears every line, so that all lines read as in R2 from the next cycle on.
- R8: When `flush` and a resolve fall in the same cycle, the resolve is discarded.
- R9: A lookup in the same cycle as a cacheable resolve or a fill to the same index returns the values written in that cycle (write-first).
- R10: A cacheable resolve and a fill to the same index in one cycle leave the resolve's values. A resolve and a fill to different indices in one cycle both take effect.
- R11: The fall-through index wraps, so line 1023 gives `lk_next_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | 10 | Line index to look up |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_last_o | output | 4 | Predicted last executed byte offset in the line |
| lk_taken_o | output | 1 | Predicted taken |
| lk_next_o | output | 10 | Next line index to fetch |
| fill_en | input | 1 | Line installed through prefetch |
| fill_idx | input | 10 | Index of the installed line |
| fix_en | input | 1 | Misprediction resolve request |
| fix_idx | input | 10 | Line index of the resolved branch |
| fix_taken | input | 1 | Actual branch outcome |
| fix_last | input | 4 | Actual last executed byte offset |
| fix_succ | input | 10 | Line index of the actual branch target |
| fix_cacheable | input | 1 | Branch came from cacheable memory |
| flush | input | 1 | Clear all predictions |

## Verification
Three pairs of events can land in the same cycle. A lookup can meet a resolve or a fill to the same line, a flush can meet a resolve, and a fill can meet a resolve. The bench drives each pair on one falling edge. For the write-first case it judges the lookup answer returned in the very next cycle. For the flush, fill and resolve collisions it uses follow-up lookups to see which write survived, on both the shared line and separate lines.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  // Fall-through successor of a line, wrapping at the array size.
  function automatic int unsigned line_after(input int unsigned idx,
                                             input int unsigned lines);
    return (idx + 1) % lines;
  endfunction

endpackage

// File: rtl/cbp_write_ctl.sv
module cbp_write_ctl #(
  parameter int unsigned IDX_W = 10
) (
  input  logic             flush,
  input  logic             fix_en,
  input  logic             fix_cacheable,
  input  logic [IDX_W-1:0] fix_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  output logic             wipe_all,
  output logic             data_we,
  output logic [IDX_W-1:0] data_idx,
  output logic             drop_en,
  output logic [IDX_W-1:0] drop_idx
);

  logic same_line;

  always_comb begin
    same_line = (fix_idx == fill_idx);
    wipe_all  = flush;
    // Flush outranks everything; a non-cacheable resolve never writes.
    data_we   = fix_en && fix_cacheable && !flush;
    data_idx  = fix_idx;
    // Fill marks its line invalid unless a resolve claims the same line.
    drop_en   = fill_en && !flush && !(data_we && same_line);
    drop_idx  = fill_idx;
  end

endmodule

// File: rtl/cbp_store.sv
module cbp_store #(
  parameter int unsigned LINES = 1024,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ENT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe_all,
  input  logic             data_we,
  input  logic [IDX_W-1:0] data_idx,
  input  logic [ENT_W-1:0] data_wr,
  input  logic             drop_en,
  input  logic [IDX_W-1:0] drop_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [ENT_W-1:0] rd_ent
);

  logic [LINES-1:0]            vld_q;
  logic [LINES-1:0]            vld_d;
  logic                        vld_ce;
  logic [LINES-1:0][ENT_W-1:0] ent_q;

  // Next state of the valid flags.
  always_comb begin
    vld_ce = wipe_all || data_we || drop_en;
    vld_d  = vld_q;
    if (wipe_all) begin
      vld_d = '0;
    end else begin
      if (drop_en)  vld_d[drop_idx] = 1'b0;
      if (data_we)  vld_d[data_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= '0;
    else if (vld_ce) vld_q <= vld_d;
  end

  // Record fields: no reset, guarded by the valid flags.
  for (genvar g = 0; g < LINES; g++) begin : g_ent
    logic ent_ce;
    always_comb ent_ce = data_we && (data_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (ent_ce) ent_q[g] <= data_wr;
    end
  end

  always_comb begin
    rd_vld = vld_q[rd_idx];
    rd_ent = ent_q[rd_idx];
  end

  assert_wipe_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_all |=> (vld_q == '0));

  assert_drop_invalidates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_en && !wipe_all && !(data_we && data_idx == drop_idx)) |=> !vld_q[$past(drop_idx)]);

endmodule

// File: rtl/cbp_lookup.sv
module cbp_lookup #(
  parameter int unsigned LINES = 1024,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFS_W = 4,
  parameter int unsigned ENT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_vld,
  input  logic [ENT_W-1:0] rd_ent,
  output logic             lk_vld_o,
  output logic [OFS_W-1:0] lk_last_o,
  output logic             lk_taken_o,
  output logic [IDX_W-1:0] lk_next_o
);

  import cbp_pkg::*;

  logic             req_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic [IDX_W-1:0] succ_f;
  logic [OFS_W-1:0] last_f;
  logic             tkn_f;
  logic [IDX_W-1:0] fall_idx;

  always_comb idx_d = lk_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
    end else begin
      req_q <= lk_req;
      if (lk_req) idx_q <= idx_d;
    end
  end

  // Record layout: {taken, last, successor}.
  always_comb begin
    rd_idx   = idx_q;
    succ_f   = rd_ent[IDX_W-1:0];
    last_f   = rd_ent[IDX_W +: OFS_W];
    tkn_f    = rd_ent[ENT_W-1];
    fall_idx = IDX_W'(line_after(int'(idx_q), LINES));
    lk_vld_o   = req_q;
    lk_taken_o = rd_vld && tkn_f;
    lk_last_o  = rd_vld ? last_f : {OFS_W{1'b1}};
    lk_next_o  = (rd_vld && tkn_f) ? succ_f : fall_idx;
  end

  assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld_o && !lk_taken_o && (rd_idx == IDX_W'(LINES - 1))) |-> (lk_next_o == '0));

endmodule

// File: rtl/cbp_line_predictor.sv
module cbp_line_predictor #(
  parameter int unsigned LINES     = 1024,
  parameter int unsigned BLK_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lk_req,
  input  logic [$clog2(LINES)-1:0]     lk_idx,
  output logic                         lk_vld_o,
  output logic [$clog2(BLK_BYTES)-1:0] lk_last_o,
  output logic                         lk_taken_o,
  output logic [$clog2(LINES)-1:0]     lk_next_o,
  input  logic                         fill_en,
  input  logic [$clog2(LINES)-1:0]     fill_idx,
  input  logic                         fix_en,
  input  logic [$clog2(LINES)-1:0]     fix_idx,
  input  logic                         fix_taken,
  input  logic [$clog2(BLK_BYTES)-1:0] fix_last,
  input  logic [$clog2(LINES)-1:0]     fix_succ,
  input  logic                         fix_cacheable,
  input  logic                         flush
);

  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned OFS_W = $clog2(BLK_BYTES);
  localparam int unsigned ENT_W = 1 + OFS_W + IDX_W;

  logic             wipe_all;
  logic             data_we;
  logic [IDX_W-1:0] data_idx;
  logic [ENT_W-1:0] data_wr;
  logic             drop_en;
  logic [IDX_W-1:0] drop_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_vld;
  logic [ENT_W-1:0] rd_ent;

  always_comb data_wr = {fix_taken, fix_last, fix_succ};

  cbp_write_ctl #(.IDX_W(IDX_W)) u_wctl (
    .flush(flush), .fix_en(fix_en), .fix_cacheable(fix_cacheable),
    .fix_idx(fix_idx), .fill_en(fill_en), .fill_idx(fill_idx),
    .wipe_all(wipe_all), .data_we(data_we), .data_idx(data_idx),
    .drop_en(drop_en), .drop_idx(drop_idx)
  );

  cbp_store #(.LINES(LINES), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wipe_all(wipe_all), .data_we(data_we),
    .data_idx(data_idx), .data_wr(data_wr), .drop_en(drop_en),
    .drop_idx(drop_idx), .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_ent(rd_ent)
  );

  cbp_lookup #(.LINES(LINES), .IDX_W(IDX_W), .OFS_W(OFS_W), .ENT_W(ENT_W)) u_lkp (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_idx(lk_idx),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_ent(rd_ent),
    .lk_vld_o(lk_vld_o), .lk_last_o(lk_last_o), .lk_taken_o(lk_taken_o),
    .lk_next_o(lk_next_o)
  );

  assert_lookup_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_vld_o);

  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_vld_o);

  assert_noncacheable_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && !fix_cacheable) |-> !data_we);

  assert_flush_then_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_taken_o);

  assert_flush_beats_fix_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && fix_en) |-> !data_we);

  assert_bypass_fix_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && fix_en && fix_cacheable && !flush && fix_idx == lk_idx)
      |=> (lk_taken_o == $past(fix_taken)) && (lk_last_o == $past(fix_last)));

  assert_bypass_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && fill_en && !fix_en && fill_idx == lk_idx)
      |=> !lk_taken_o && (lk_next_o == $past(lk_idx) + IDX_W'(1)));

endmodule

// File: tb/cbp_line_predictor_bench.sv
`timescale 1ns/1ps
module cbp_line_predictor_bench;

  logic       clk;
  logic       rst_n;
  logic       lk_req;
  logic [9:0] lk_idx;
  logic       lk_vld_o;
  logic [3:0] lk_last_o;
  logic       lk_taken_o;
  logic [9:0] lk_next_o;
  logic       fill_en;
  logic [9:0] fill_idx;
  logic       fix_en;
  logic [9:0] fix_idx;
  logic       fix_taken;
  logic [3:0] fix_last;
  logic [9:0] fix_succ;
  logic       fix_cacheable;
  logic       flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cbp_line_predictor u_cbp_line_predictor (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_req = 0; lk_idx = 0; fill_en = 0; fill_idx = 0; fix_en = 0; fix_idx = 0;
    fix_taken = 0; fix_last = 0; fix_succ = 0; fix_cacheable = 0; flush = 0;
  endtask

  // Drive a lookup, then compare the answer returned one cycle later.
  task automatic look(input int idx, input bit e_tkn, input int e_last,
                      input int e_next, input string req);
    @(negedge clk);
    lk_req = 1; lk_idx = 10'(idx);
    @(negedge clk);
    lk_req = 0;
    chk(lk_vld_o == 1'b1, "R1 valid", int'(lk_vld_o), 1);
    chk(lk_taken_o == e_tkn, {req, " taken"}, int'(lk_taken_o), int'(e_tkn));
    chk(lk_last_o == 4'(e_last), {req, " last"}, int'(lk_last_o), e_last);
    chk(lk_next_o == 10'(e_next), {req, " next"}, int'(lk_next_o), e_next);
  endtask

  task automatic fix(input int idx, input bit tkn, input int last, input int succ,
                     input bit cache);
    @(negedge clk);
    fix_en = 1; fix_idx = 10'(idx); fix_taken = tkn; fix_last = 4'(last);
    fix_succ = 10'(succ); fix_cacheable = cache;
    @(negedge clk);
    fix_en = 0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(lk_vld_o == 1'b0, "R1 idle", int'(lk_vld_o), 0);
    look(3, 0, 15, 4, "R2 reset");
    look(600, 0, 15, 601, "R2 reset");
    @(negedge clk);
    chk(lk_vld_o == 1'b0, "R1 drop", int'(lk_vld_o), 0);
  endtask

  task automatic t_resolve();
    fix(20, 1, 9, 333, 1);
    look(20, 1, 9, 333, "R3 taken");
    fix(21, 0, 6, 800, 1);
    look(21, 0, 6, 22, "R4 not-taken");
  endtask

  task automatic t_noncacheable();
    fix(30, 1, 12, 50, 1);
    fix(30, 0, 2, 3, 0);
    look(30, 1, 12, 50, "R5 non-cacheable");
  endtask

  task automatic t_fill();
    fix(40, 1, 5, 77, 1);
    @(negedge clk);
    fill_en = 1; fill_idx = 40;
    @(negedge clk);
    fill_en = 0;
    look(40, 0, 15, 41, "R6 fill");
  endtask

  task automatic t_flush();
    fix(50, 1, 1, 10, 1);
    fix(51, 1, 2, 11, 1);
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    look(50, 0, 15, 51, "R7 flush");
    look(51, 0, 15, 52, "R7 flush");
  endtask

  task automatic t_flush_vs_fix();
    @(negedge clk);
    flush = 1; fix_en = 1; fix_idx = 60; fix_taken = 1; fix_last = 3;
    fix_succ = 99; fix_cacheable = 1;
    @(negedge clk);
    flush = 0; fix_en = 0;
    look(60, 0, 15, 61, "R8 flush wins");
  endtask

  task automatic t_bypass();
    @(negedge clk);
    lk_req = 1; lk_idx = 70;
    fix_en = 1; fix_idx = 70; fix_taken = 1; fix_last = 11; fix_succ = 512;
    fix_cacheable = 1;
    @(negedge clk);
    lk_req = 0; fix_en = 0;
    chk(lk_taken_o == 1'b1, "R9 bypass taken", int'(lk_taken_o), 1);
    chk(lk_last_o == 4'd11, "R9 bypass last", int'(lk_last_o), 11);
    chk(lk_next_o == 10'd512, "R9 bypass next", int'(lk_next_o), 512);
    @(negedge clk);
    lk_req = 1; lk_idx = 70; fill_en = 1; fill_idx = 70;
    @(negedge clk);
    lk_req = 0; fill_en = 0;
    chk(lk_taken_o == 1'b0, "R9 fill bypass taken", int'(lk_taken_o), 0);
    chk(lk_next_o == 10'd71, "R9 fill bypass next", int'(lk_next_o), 71);
  endtask

  task automatic t_fix_vs_fill();
    @(negedge clk);
    fill_en = 1; fill_idx = 80;
    fix_en = 1; fix_idx = 80; fix_taken = 1; fix_last = 7; fix_succ = 100;
    fix_cacheable = 1;
    @(negedge clk);
    fill_en = 0; fix_en = 0;
    look(80, 1, 7, 100, "R10 same line");
    fix(81, 1, 4, 200, 1);
    @(negedge clk);
    fill_en = 1; fill_idx = 81;
    fix_en = 1; fix_idx = 82; fix_taken = 1; fix_last = 8; fix_succ = 300;
    fix_cacheable = 1;
    @(negedge clk);
    fill_en = 0; fix_en = 0;
    look(81, 0, 15, 82, "R10 split fill");
    look(82, 1, 8, 300, "R10 split fix");
  endtask

  task automatic t_wrap();
    look(1023, 0, 15, 0, "R11 wrap");
    fix(1023, 0, 13, 5, 1);
    look(1023, 0, 13, 0, "R11 wrap valid");
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_resolve();
    t_noncacheable();
    t_fill();
    t_flush();
    t_flush_vs_fix();
    t_bypass();
    t_fix_vs_fill();
    t_wrap();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule